// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit linear address into a physical address by reading two levels of translation tables held in memory. It is started when a translation cache misses. A request carries the linear address and whether the access is a write. The walker fetches the directory entry from the page named by the directory base input, then fetches the table entry that this directory entry points to. It returns the physical address together with the combined write-permission and user-access bits, or it reports a fault.

Along the way it maintains the usage flags in memory. Every entry it uses gets its accessed flag set. The leaf entry gets its dirty flag set when the access is a write. An entry is written back only when one of its flags actually changes. The read and the write-back of an entry form one locked sequence on the memory port. The faulting linear address is kept in a register that changes only when a fault is reported.

The memory port uses a request valid/ready handshake. A read returns one response pulse at some later cycle. A write completes when its request is accepted. Any number of wait cycles is tolerated on the request and on the response.

Top module: `pgwalk_top`

## Requirements
- R1: The directory entry is read at {base frame, linear[31:22], 2'b00}. The table entry is read at {directory entry[31:12], linear[21:12], 2'b00}. The base frame is sampled when the request is accepted.
- R2: A successful walk returns physical address {table entry[31:12], linear[11:0]}.
- R3: A directory or table entry whose present flag (bit 0) is 0 ends the walk with a fault result whose physical address field is 0. A missing directory entry causes no table read, and a faulting entry is never written.
- R4: On a fault, the fault address output takes the request's linear address. At all other times it holds its value.
- R5: Each entry that is read with its present flag set ends up with its accessed flag (bit 5) set in memory. No flag is ever cleared.
- R6: The table entry's dirty flag (bit 6) is set in memory for a write access. A read access leaves it unchanged, and the directory entry's dirty flag is never changed by the walker.
- R7: An entry is written back only when its accessed or dirty flag changes. The write goes to the address just read, with the lock output high.
- R8: The returned write-permission flag (bit 1) and user flag (bit 2) are each the AND of the directory and table entry bits.
- R9: A request is accepted only while the ready output is high, which holds only when no walk is in progress. Every accepted request produces exactly one single-cycle result pulse.
- R10: The results and memory contents are the same whatever wait cycles the memory applies to request acceptance and to response return.
- R11: After reset, ready is high, and result valid, memory request valid, lock and the fault address are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| dir_base | input | 20 | Physical frame of the directory |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write-back |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_lock | output | 1 | Locked sequence in progress |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk ended in a fault |
| res_paddr | output | 32 | Physical address |
| res_rw | output | 1 | Combined write permission |
| res_us | output | 1 | Combined user access |
| fault_addr | output | 32 | Last faulting linear address |

## Verification
Walks are run with entries whose flags are both clear, already set, or set by an earlier walk. This separates the write-back decision from the plain translation, since the number of memory writes changes while the address stays the same. Read and write accesses to the same page show that the dirty flag follows the access type and is set only on the leaf entry. A missing directory entry and a missing table entry produce different read counts and different directory write-back counts, which pins down where the walk stops. Several addresses at the index and offset extremes, permission mixes, and a switch of directory base are run first with a zero-wait memory and then with random request and response delays.

// File: rtl/pgwalk_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 4-byte entries and an entry count per table that fills one page.
package pgwalk_pkg;
    localparam int OFF_W_DEF = 12;
    localparam int IDX_W_DEF = 10;

    // Flag positions inside every entry
    localparam int BIT_PRESENT = 0;
    localparam int BIT_RW      = 1;
    localparam int BIT_US      = 2;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PDE,
        ST_UPD_PDE,
        ST_READ_PTE,
        ST_UPD_PTE,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/pgwalk_addr.sv
// Address formation for the walk: directory entry address, table entry
// address and final physical address. Purely combinational.
// Assumes entry size in bytes is 2**(OFF_W-IDX_W).
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter  int OFF_W   = OFF_W_DEF,
    parameter  int IDX_W   = IDX_W_DEF,
    localparam int ADDR_W  = OFF_W + 2 * IDX_W,
    localparam int FRAME_W = ADDR_W - OFF_W,
    localparam int ENT_LG  = OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0]  va_i,
    input  logic [FRAME_W-1:0] dir_frame_i,
    input  logic [ADDR_W-1:0]  pde_i,
    input  logic [ADDR_W-1:0]  pte_i,
    output logic [ADDR_W-1:0]  pde_addr_o,
    output logic [ADDR_W-1:0]  pte_addr_o,
    output logic [ADDR_W-1:0]  phys_o
);
    // Concatenate frame, index and entry-size zeros
    always_comb begin
        pde_addr_o = {dir_frame_i, va_i[ADDR_W-1 -: IDX_W], {ENT_LG{1'b0}}};
        pte_addr_o = {pde_i[ADDR_W-1 -: FRAME_W], va_i[OFF_W +: IDX_W], {ENT_LG{1'b0}}};
        phys_o     = {pte_i[ADDR_W-1 -: FRAME_W], va_i[OFF_W-1:0]};
    end
endmodule

// File: rtl/pgwalk_flags.sv
// Flag update for one fetched entry: present test, accessed set and, for
// the leaf level only, dirty set on writes. Reports whether a write-back
// is needed. Assumes flags are only ever set, never cleared.
module pgwalk_flags
    import pgwalk_pkg::*;
#(
    parameter int W    = 32,
    parameter bit LEAF = 1'b0
) (
    input  logic [W-1:0] entry_i,
    input  logic         is_write_i,
    output logic         present_o,
    output logic [W-1:0] upd_o,
    output logic         wb_o
);
    logic [W-1:0] dirty_mask;

    // Dirty marking exists only at the leaf level
    generate
        if (LEAF) begin : g_leaf
            always_comb dirty_mask = is_write_i ? (W'(1) << BIT_DIRTY) : '0;
        end else begin : g_dir
            always_comb dirty_mask = '0;
        end
    endgenerate

    // Merge flags and decide on write-back
    always_comb begin
        present_o = entry_i[BIT_PRESENT];
        upd_o     = entry_i | (W'(1) << BIT_ACC) | dirty_mask;
        wb_o      = present_o && (upd_o != entry_i);
    end
endmodule

// File: rtl/pgwalk_fsm.sv
// Walk sequencer: accepts a request in idle, reads the directory entry,
// optionally writes it back, reads the table entry, optionally writes it
// back, then presents a one-cycle result or fault. Holds the request
// fields and fetched entries. Assumes one outstanding memory read, with the
// response arriving at least one cycle after the read is accepted.
module pgwalk_fsm
    import pgwalk_pkg::*;
#(
    parameter  int OFF_W   = OFF_W_DEF,
    parameter  int IDX_W   = IDX_W_DEF,
    localparam int ADDR_W  = OFF_W + 2 * IDX_W,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               req_write,
    input  logic [FRAME_W-1:0] dir_frame_i,
    output logic [FRAME_W-1:0] dir_frame_q,
    output logic [ADDR_W-1:0]  va_q,
    output logic               write_q,
    output logic [ADDR_W-1:0]  pde_q,
    output logic [ADDR_W-1:0]  pte_q,
    input  logic [ADDR_W-1:0]  pde_addr_i,
    input  logic [ADDR_W-1:0]  pte_addr_i,
    input  logic [ADDR_W-1:0]  phys_i,
    input  logic               pde_present_i,
    input  logic               pde_wb_i,
    input  logic [ADDR_W-1:0]  pde_upd_i,
    input  logic               pte_present_i,
    input  logic               pte_wb_i,
    input  logic [ADDR_W-1:0]  pte_upd_i,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [ADDR_W-1:0]  mem_req_wdata,
    output logic               mem_lock,
    input  logic               mem_rsp_valid,
    output logic               res_valid,
    output logic               res_fault,
    output logic [ADDR_W-1:0]  res_paddr,
    output logic               res_rw,
    output logic               res_us,
    output logic [ADDR_W-1:0]  fault_addr
);
    walk_state_e state_q;
    logic        issued_q;
    logic        in_read, in_upd, on_dir, rsp_take, miss_now;

    // Decode the state into port-level controls
    always_comb begin
        in_read       = (state_q == ST_READ_PDE) || (state_q == ST_READ_PTE);
        in_upd        = (state_q == ST_UPD_PDE) || (state_q == ST_UPD_PTE);
        on_dir        = (state_q == ST_READ_PDE) || (state_q == ST_UPD_PDE);
        rsp_take      = in_read && issued_q && mem_rsp_valid;
        miss_now      = rsp_take && (on_dir ? !pde_present_i : !pte_present_i);
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (in_read && !issued_q) || in_upd;
        mem_req_write = in_upd;
        mem_lock      = in_read || in_upd;
        mem_req_addr  = on_dir ? pde_addr_i : pte_addr_i;
        mem_req_wdata = on_dir ? pde_q : pte_q;
        res_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
        res_fault     = (state_q == ST_FAULT);
        res_paddr     = (state_q == ST_DONE) ? phys_i : '0;
        res_rw        = (state_q == ST_DONE) && pde_q[BIT_RW] && pte_q[BIT_RW];
        res_us        = (state_q == ST_DONE) && pde_q[BIT_US] && pte_q[BIT_US];
    end

    // Capture request fields when a walk starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            write_q     <= 1'b0;
            dir_frame_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            va_q        <= req_vaddr;
            write_q     <= req_write;
            dir_frame_q <= dir_frame_i;
        end
    end

    // Hold fetched entries with their updated flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pde_q <= '0;
            pte_q <= '0;
        end else if (rsp_take) begin
            if (on_dir) pde_q <= pde_upd_i;
            else        pte_q <= pte_upd_i;
        end
    end

    // Track whether the current read has been accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                           issued_q <= 1'b0;
        else if (rsp_take)                    issued_q <= 1'b0;
        else if (in_read && mem_req_ready)    issued_q <= 1'b1;
    end

    // Remember the linear address of the latest fault
    always_ff @(posedge clk) begin
        if (!rst_n)        fault_addr <= '0;
        else if (miss_now) fault_addr <= va_q;
    end

    // Walk state transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:     if (req_valid) state_q <= ST_READ_PDE;
                ST_READ_PDE: if (rsp_take) begin
                                 if (!pde_present_i) state_q <= ST_FAULT;
                                 else if (pde_wb_i)  state_q <= ST_UPD_PDE;
                                 else                state_q <= ST_READ_PTE;
                             end
                ST_UPD_PDE:  if (mem_req_ready) state_q <= ST_READ_PTE;
                ST_READ_PTE: if (rsp_take) begin
                                 if (!pte_present_i) state_q <= ST_FAULT;
                                 else if (pte_wb_i)  state_q <= ST_UPD_PTE;
                                 else                state_q <= ST_DONE;
                             end
                ST_UPD_PTE:  if (mem_req_ready) state_q <= ST_DONE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    // A pending request keeps its address and direction until accepted
    assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                            && $stable(mem_req_write));

    // Memory is only driven while a walk is running
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // Results are single pulses followed by idle
    assert_result_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && req_ready);

    // Write-backs happen only inside the locked window
    assert_write_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_lock);

    // Written entries are present and carry the accessed flag
    assert_wb_accessed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[BIT_ACC] && mem_req_wdata[BIT_PRESENT]);

    // The fault register shows the faulting address during a fault result
    assert_fault_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> fault_addr == va_q);

    // The fault register moves only on entry to the fault state
    assert_fault_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> state_q == ST_FAULT);

    // A fault result carries no physical address
    assert_fault_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> res_paddr == '0 && !res_rw && !res_us);
endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker. Connects the sequencer, the address
// formation and one flag-update unit per table level. The read data is
// examined as it arrives, so the write-back decision costs no extra cycle.
// Assumes the memory returns exactly one response per accepted read.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter  int OFF_W   = OFF_W_DEF,
    parameter  int IDX_W   = IDX_W_DEF,
    localparam int ADDR_W  = OFF_W + 2 * IDX_W,
    localparam int FRAME_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               req_write,
    input  logic [FRAME_W-1:0] dir_base,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [ADDR_W-1:0]  mem_req_wdata,
    output logic               mem_lock,
    input  logic               mem_rsp_valid,
    input  logic [ADDR_W-1:0]  mem_rsp_rdata,
    output logic               res_valid,
    output logic               res_fault,
    output logic [ADDR_W-1:0]  res_paddr,
    output logic               res_rw,
    output logic               res_us,
    output logic [ADDR_W-1:0]  fault_addr
);
    logic [FRAME_W-1:0] dir_frame_q;
    logic [ADDR_W-1:0]  va_q, pde_q, pte_q;
    logic               write_q;
    logic [ADDR_W-1:0]  pde_addr, pte_addr, phys;
    logic               pde_present, pde_wb, pte_present, pte_wb;
    logic [ADDR_W-1:0]  pde_upd, pte_upd;

    pgwalk_addr #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
        .va_i        (va_q),
        .dir_frame_i (dir_frame_q),
        .pde_i       (pde_q),
        .pte_i       (pte_q),
        .pde_addr_o  (pde_addr),
        .pte_addr_o  (pte_addr),
        .phys_o      (phys)
    );

    pgwalk_flags #(.W(ADDR_W), .LEAF(1'b0)) u_dir_flags (
        .entry_i    (mem_rsp_rdata),
        .is_write_i (write_q),
        .present_o  (pde_present),
        .upd_o      (pde_upd),
        .wb_o       (pde_wb)
    );

    pgwalk_flags #(.W(ADDR_W), .LEAF(1'b1)) u_leaf_flags (
        .entry_i    (mem_rsp_rdata),
        .is_write_i (write_q),
        .present_o  (pte_present),
        .upd_o      (pte_upd),
        .wb_o       (pte_wb)
    );

    pgwalk_fsm #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .dir_frame_i   (dir_base),
        .dir_frame_q   (dir_frame_q),
        .va_q          (va_q),
        .write_q       (write_q),
        .pde_q         (pde_q),
        .pte_q         (pte_q),
        .pde_addr_i    (pde_addr),
        .pte_addr_i    (pte_addr),
        .phys_i        (phys),
        .pde_present_i (pde_present),
        .pde_wb_i      (pde_wb),
        .pde_upd_i     (pde_upd),
        .pte_present_i (pte_present),
        .pte_wb_i      (pte_wb),
        .pte_upd_i     (pte_upd),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_lock      (mem_lock),
        .mem_rsp_valid (mem_rsp_valid),
        .res_valid     (res_valid),
        .res_fault     (res_fault),
        .res_paddr     (res_paddr),
        .res_rw        (res_rw),
        .res_us        (res_us),
        .fault_addr    (fault_addr)
    );
endmodule

// File: tb/tb_pgwalk_top.sv
// Scoreboard bench: the driver computes each walk's expected outcome from
// its own memory model and queues it; the monitor compares on each result.
module tb_pgwalk_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_vaddr;
    logic [19:0] dir_base;
    logic        mem_req_valid, mem_req_ready, mem_req_write, mem_lock;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        res_valid, res_fault, res_rw, res_us;
    logic [31:0] res_paddr, fault_addr;

    pgwalk_top dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .dir_base(dir_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_lock(mem_lock),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr),
        .res_rw(res_rw), .res_us(res_us), .fault_addr(fault_addr)
    );

    int checks = 0, errors = 0;
    int n_reads = 0, n_writes = 0, lock_bad = 0, results = 0;
    int wait_max = 0;
    bit done_flag = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] read_log [$];
    logic [31:0] last_read = '0;
    logic [31:0] exp_faddr = '0;

    typedef struct {
        string       tag;
        logic        fault;
        logic [31:0] paddr;
        logic        rw, us;
        logic [31:0] faddr;
        int          reads, writes, reads0, writes0, log0;
        logic [31:0] pde_a, pde_v, pte_a, pte_v;
    } exp_t;
    exp_t sb [$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model with random acceptance and response delays
    int rsp_cnt = -1;
    logic [31:0] rsp_data;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            rsp_cnt = -1;
        end else begin
            mem_rsp_valid = 1'b0;
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = rsp_data;
            end
            if (rsp_cnt >= 0) rsp_cnt--;
            mem_req_ready = (wait_max == 0) ? 1'b1 : ($urandom_range(0, wait_max) == 0);
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    n_writes++;
                    if (!mem_lock || mem_req_addr != last_read) lock_bad++;
                    mem[mem_req_addr] = mem_req_wdata;
                end else begin
                    n_reads++;
                    last_read = mem_req_addr;
                    read_log.push_back(mem_req_addr);
                    rsp_data = rd(mem_req_addr);
                    rsp_cnt = (wait_max == 0) ? 0 : $urandom_range(0, wait_max);
                end
            end
        end
    end

    // Monitor: compare each result with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: actual unexpected result expected none");
            end else begin
                e = sb.pop_front();
                chk({"R3 fault ", e.tag}, {31'b0, res_fault}, {31'b0, e.fault});
                chk({"R2 paddr ", e.tag}, res_paddr, e.paddr);
                chk({"R8 rw ", e.tag}, {31'b0, res_rw}, {31'b0, e.rw});
                chk({"R8 us ", e.tag}, {31'b0, res_us}, {31'b0, e.us});
                chk({"R4 fault_addr ", e.tag}, fault_addr, e.faddr);
                chk({"R3 reads ", e.tag}, n_reads - e.reads0, e.reads);
                chk({"R7 writes ", e.tag}, n_writes - e.writes0, e.writes);
                chk({"R1 dir addr ", e.tag}, read_log[e.log0], e.pde_a);
                chk({"R5 dir entry ", e.tag}, rd(e.pde_a), e.pde_v);
                if (e.reads == 2) begin
                    chk({"R1 table addr ", e.tag}, read_log[e.log0 + 1], e.pte_a);
                    chk({"R6 table entry ", e.tag}, rd(e.pte_a), e.pte_v);
                end
            end
            results++;
        end
    end

    // Driver: compute the expected outcome, queue it, run the walk
    task automatic walk(string tag, logic [31:0] va, logic wr);
        exp_t e;
        logic [31:0] pde, pte;
        int target;
        e.tag = tag; e.fault = 1'b0; e.paddr = '0; e.rw = 1'b0; e.us = 1'b0;
        e.reads0 = n_reads; e.writes0 = n_writes; e.log0 = read_log.size();
        e.pde_a = {dir_base, va[31:22], 2'b00};
        pde = rd(e.pde_a);
        e.pde_v = pde; e.reads = 1; e.writes = 0; e.pte_a = '0; e.pte_v = '0;
        if (!pde[0]) begin
            e.fault = 1'b1;
        end else begin
            e.pde_v = pde | 32'h20;
            if (e.pde_v != pde) e.writes++;
            e.pte_a = {pde[31:12], va[21:12], 2'b00};
            pte = rd(e.pte_a);
            e.reads = 2; e.pte_v = pte;
            if (!pte[0]) begin
                e.fault = 1'b1;
            end else begin
                e.pte_v = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                if (e.pte_v != pte) e.writes++;
                e.paddr = {pte[31:12], va[11:0]};
                e.rw = pde[1] & pte[1];
                e.us = pde[2] & pte[2];
            end
        end
        if (e.fault) exp_faddr = va;
        e.faddr = exp_faddr;
        sb.push_back(e);
        target = results + 1;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({"R9 busy ", tag}, {31'b0, req_ready}, 32'h0);
        while (results < target) @(negedge clk);
    endtask

    task automatic setup_tables();
        mem.delete();
        mem[32'h0010_0004] = 32'h0030_0007;   // dir0 idx1 -> table 0x300
        mem[32'h0030_0014] = 32'h1234_5007;   // idx5 -> frame 0x12345
        mem[32'h0010_0008] = 32'h0040_0006;   // dir0 idx2 missing
        mem[32'h0010_000C] = 32'h0050_0003;   // dir0 idx3 -> table 0x500
        mem[32'h0050_0FFC] = 32'h7777_7006;   // idx 3FF missing
        mem[32'h0010_0FFC] = 32'h0060_0003;   // dir0 idx 3FF rw=1 us=0
        mem[32'h0060_0000] = 32'hABCD_E005;   // idx0 rw=0 us=1
        mem[32'h0020_0004] = 32'h0070_0067;   // dir1 idx1 flags already set
        mem[32'h0070_0014] = 32'h0FED_C027;   // accessed already set
    endtask

    task automatic run_set(string mode);
        setup_tables();
        dir_base = 20'h00100;
        walk({"R5 first read ", mode}, 32'h0040_5ABC, 1'b0);
        walk({"R7 repeat read ", mode}, 32'h0040_5ABC, 1'b0);
        walk({"R6 first write ", mode}, 32'h0040_5ABC, 1'b1);
        walk({"R7 repeat write ", mode}, 32'h0040_5000, 1'b1);
        walk({"R3 dir missing ", mode}, 32'h0080_0123, 1'b0);
        walk({"R3 table missing ", mode}, 32'h00FF_F000, 1'b1);
        walk({"R8 perm mix ", mode}, 32'hFFC0_0FFF, 1'b0);
        dir_base = 20'h00200;
        walk({"R1 base switch ", mode}, 32'h0040_5ABC, 1'b0);
        walk({"R6 dir dirty kept ", mode}, 32'h0040_5ABC, 1'b1);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
        dir_base = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready", {31'b0, req_ready}, 32'h1);
        chk("R11 res_valid", {31'b0, res_valid}, 32'h0);
        chk("R11 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
        chk("R11 lock", {31'b0, mem_lock}, 32'h0);
        chk("R11 fault_addr", fault_addr, 32'h0);
        wait_max = 0;
        run_set("nowait");
        wait_max = 4;       // R10: same outcomes under random delays
        run_set("R10 delayed");
        repeat (5) @(negedge clk);
        chk("R7 locked write-back to last read", lock_bad, 0);
        chk("R9 all results seen", sb.size(), 0);
        finish_run();
    end
endmodule